// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a single-word request port to a synchronous DRAM with four banks and a 16-bit data path. After reset it runs the power-up sequence. It then serves each accepted request as one closed-page access: it activates the row, issues one read or write of one word, and precharges that bank. The block holds at most one row open at any time. It also schedules the periodic auto refresh the memory needs. All minimum spacings between commands are enforced by clock-cycle counters. These counters are derived from parameters for the clock period and for the row timings in nanoseconds. Read data is captured after the CAS latency that was programmed into the memory at start-up.

The request port carries a flat word address. The address splits into a 2-bit bank, a 12-bit row and an 8-bit column. A request is taken on a clock edge where `req_valid` and `ready` are both high. Read results come back on `rd_data` with a one-cycle `rd_valid` pulse.

The controller is a single state machine:

- **Power-up path:** `S_PWR` waits for the start-up delay, then moves to `S_IPRE` (precharge all). `S_IRP` waits out the precharge time and leads to `S_IREF` (refresh). `S_IRFC` waits the refresh cycle time and goes back to `S_IREF` until two refreshes are done, then to `S_IMRS` (mode load). `S_IMRD` waits the mode-load time and enters `S_IDLE`.
- **Idle:** from `S_IDLE`, an owed refresh goes to `S_REF` and then `S_RFC`. Otherwise an accepted request goes to `S_ACT`.
- **Access path:** `S_ACT` leads to `S_RCD`, which waits the activate-to-column delay. `S_RW` issues the read or write. `S_RAS` holds until the minimum row-active time has run. `S_PRE` then closes the bank and `S_RP` returns to `S_IDLE`.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: The command is driven on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} with these codes: NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000. No other code ever appears after reset.
- R2: After reset the controller holds NOP for at least INIT_CYC = ceil(INIT_US*1000/CLK_NS) cycles. It then issues one PRECHARGE with sd_addr[10]=1, then exactly two AUTO REFRESH, then one LOAD MODE. No ACTIVE, READ or WRITE occurs before that LOAD MODE.
- R3: The LOAD MODE word on sd_addr holds the CAS latency in bits [6:4] (010 for 2, 011 for 3), and every other bit is 0 (burst of one, sequential). The latency is 3 when cfg_cas3 is high during reset and the start-up wait, and 2 otherwise. Later changes of cfg_cas3 have no effect until the next reset.
- R4: req_addr[21:20] is the bank on sd_ba, and req_addr[19:8] is the row on sd_addr with ACTIVE. With READ/WRITE, sd_addr[7:0] carries req_addr[7:0] and sd_addr[11:8] is 0, so bit 10 is low and no auto-precharge is requested.
- R5: A READ or WRITE follows its ACTIVE by at least RCD = ceil(18/6) = 3 cycles.
- R6: A PRECHARGE follows the ACTIVE of its bank by at least ceil(42/6) = 7 cycles. Two ACTIVE commands are at least ceil(60/6) = 10 cycles apart.
- R7: An ACTIVE or AUTO REFRESH follows a PRECHARGE by at least 3 cycles. Any ACTIVE, AUTO REFRESH or LOAD MODE follows an AUTO REFRESH by at least 10 cycles.
- R8: Every access ends with a PRECHARGE to the same bank with sd_addr[10]=0 before the next ACTIVE or AUTO REFRESH. At most one row is open at a time.
- R9: After the power-up sequence, two consecutive AUTO REFRESH commands are never more than floor(64e6/4096/6) = 2604 cycles apart. This holds even with a request waiting on every cycle, because an owed refresh is served before the next request.
- R10: sd_dq_oe is high only in the WRITE command cycle, and in that cycle sd_dq_out equals the request's write data.
- R11: For a READ issued in cycle t, sd_dq_in is sampled at the end of cycle t+CL. rd_valid is high for exactly one cycle, cycle t+CL+1, with that word on rd_data.
- R12: ready is 0 during reset and the power-up sequence. It is 0 while an access or refresh is in progress or a refresh is owed, and 0 in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas3 | input | 1 | Latency select sampled during start-up: 1 = three cycles, 0 = two |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Request taken on this edge if req_valid is high |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Captured read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row, column or mode word |
| sd_dq_out | output | 16 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned by the memory |

## Verification
The embedded assertions check on every cycle these rules: no ACTIVE lands inside the row-cycle window, and no access-closing PRECHARGE comes before the row-active time has run. An accepted refresh clears the owed flag. The read-valid output never lasts two cycles. No column or row command is issued before start-up completes. Other behaviours only show through the bench's scenarios, which compare against a behavioural memory and request scoreboard. These are the exact order and address bits of the start-up sequence and the latency coded into the mode word. They also include the address split across banks, the return of the correct word exactly CL+1 cycles after its READ, and that refresh keeps its spacing under continuous traffic and after a reset with the other latency.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [4:0] {
        S_PWR,
        S_IPRE,
        S_IRP,
        S_IREF,
        S_IRFC,
        S_IMRS,
        S_IMRD,
        S_IDLE,
        S_ACT,
        S_RCD,
        S_RW,
        S_RAS,
        S_PRE,
        S_RP,
        S_REF,
        S_RFC
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // wait-state counts need at least two cycles between commands
    function automatic int at_least_two(input int v);
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/sdram_row_timer.sv
module sdram_row_timer #(
    parameter int RAS_CYC = 7,
    parameter int RC_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic ras_ok,
    output logic rc_ok
);
    localparam int CW = $clog2(RC_CYC + 1);

    logic [CW-1:0] ras_left;
    logic [CW-1:0] rc_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_left <= '0;
            rc_left  <= '0;
        end else if (act) begin
            ras_left <= CW'(RAS_CYC - 1);
            rc_left  <= CW'(RC_CYC - 1);
        end else begin
            if (ras_left != '0) ras_left <= ras_left - 1'b1;
            if (rc_left != '0)  rc_left  <= rc_left - 1'b1;
        end
    end

    assign ras_ok = (ras_left == '0);
    assign rc_ok  = (rc_left == '0);

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int TRIG_CYC = 2574
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(TRIG_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (ack) pend <= 1'b0;
            if (cnt == CW'(TRIG_CYC - 1)) begin
                cnt  <= '0;
                pend <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // an issued refresh retires the owed flag (R9)
    p_ref_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ack) |=> !pend);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
    parameter int DQ_W  = 16,
    parameter int CL_LO = 2,
    parameter int CL_HI = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_issue,
    input  logic            cl_hi_sel,
    input  logic [DQ_W-1:0] dq_in,
    output logic            rd_valid,
    output logic [DQ_W-1:0] rd_data
);
    logic [CL_HI-1:0] pipe;
    logic             tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= rd_issue;
    end

    for (genvar k = 1; k < CL_HI; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[k] <= 1'b0;
            else        pipe[k] <= pipe[k-1];
        end
    end

    assign tap = cl_hi_sel ? pipe[CL_HI-1] : pipe[CL_LO-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= tap;
            if (tap) rd_data <= dq_in;
        end
    end

    // single-word reads give a one-cycle strobe (R11)
    p_rdv_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int CLK_NS     = 6,
    parameter int T_RAS_NS   = 42,
    parameter int T_RC_NS    = 60,
    parameter int T_RCD_NS   = 18,
    parameter int T_RP_NS    = 18,
    parameter int T_RFC_NS   = 60,
    parameter int T_MRD_CYC  = 2,
    parameter int REF_WIN_US = 64000,
    parameter int REF_ROWS   = 4096,
    parameter int INIT_US    = 100,
    parameter int INIT_REFS  = 2,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int COL_W      = 8,
    parameter int DQ_W       = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_cas3,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]  req_addr,
    input  logic [DQ_W-1:0]                req_wdata,
    output logic                           ready,
    output logic                           rd_valid,
    output logic [DQ_W-1:0]                rd_data,
    output logic                           sd_cs_n,
    output logic                           sd_ras_n,
    output logic                           sd_cas_n,
    output logic                           sd_we_n,
    output logic [BANK_W-1:0]              sd_ba,
    output logic [ROW_W-1:0]               sd_addr,
    output logic [DQ_W-1:0]                sd_dq_out,
    output logic                           sd_dq_oe,
    input  logic [DQ_W-1:0]                sd_dq_in
);
    localparam int AP_BIT    = 10;
    localparam int MR_CL_LSB = 4;
    localparam int RAS_CYC   = at_least_two(ceil_div(T_RAS_NS, CLK_NS));
    localparam int RC_CYC    = at_least_two(ceil_div(T_RC_NS, CLK_NS));
    localparam int RCD_CYC   = at_least_two(ceil_div(T_RCD_NS, CLK_NS));
    localparam int RP_CYC    = at_least_two(ceil_div(T_RP_NS, CLK_NS));
    localparam int RFC_CYC   = at_least_two(ceil_div(T_RFC_NS, CLK_NS));
    localparam int MRD_CYC   = at_least_two(T_MRD_CYC);
    localparam int REF_CYC   = (REF_WIN_US * 1000 / REF_ROWS) / CLK_NS;
    localparam int REF_TRIG  = REF_CYC - 2 * RC_CYC - RFC_CYC;
    localparam int INIT_CYC  = ceil_div(INIT_US * 1000, CLK_NS);
    localparam int TW        = $clog2(INIT_CYC + RFC_CYC + 1);
    localparam int RCW       = $clog2(INIT_REFS + 1);

    seq_state_e          state, state_d;
    logic [TW-1:0]       tmr, tmr_d;
    logic [RCW-1:0]      ref_cnt;
    logic                cl3_q;
    logic                init_done;
    logic                ref_pend;
    logic                ras_ok, rc_ok;
    logic                accept;
    logic                q_wr;
    logic [BANK_W-1:0]   q_bank;
    logic [ROW_W-1:0]    q_row;
    logic [COL_W-1:0]    q_col;
    logic [DQ_W-1:0]     q_data;
    sd_cmd_e             cmd;

    assign ready  = (state == S_IDLE) && !ref_pend && rc_ok;
    assign accept = ready && req_valid;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state;
        tmr_d   = (tmr != '0) ? tmr - 1'b1 : tmr;
        unique case (state)
            S_PWR:  if (tmr == '0) state_d = S_IPRE;
            S_IPRE: begin state_d = S_IRP;  tmr_d = TW'(RP_CYC - 2);  end
            S_IRP:  if (tmr == '0) state_d = S_IREF;
            S_IREF: begin state_d = S_IRFC; tmr_d = TW'(RFC_CYC - 2); end
            S_IRFC: if (tmr == '0)
                        state_d = (ref_cnt == RCW'(INIT_REFS)) ? S_IMRS : S_IREF;
            S_IMRS: begin state_d = S_IMRD; tmr_d = TW'(MRD_CYC - 2); end
            S_IMRD: if (tmr == '0) state_d = S_IDLE;
            S_IDLE: begin
                if (ref_pend)    state_d = S_REF;
                else if (accept) state_d = S_ACT;
            end
            S_ACT:  begin state_d = S_RCD;  tmr_d = TW'(RCD_CYC - 2); end
            S_RCD:  if (tmr == '0) state_d = S_RW;
            S_RW:   state_d = S_RAS;
            S_RAS:  if (ras_ok) state_d = S_PRE;
            S_PRE:  begin state_d = S_RP;   tmr_d = TW'(RP_CYC - 2);  end
            S_RP:   if (tmr == '0) state_d = S_IDLE;
            S_REF:  begin state_d = S_RFC;  tmr_d = TW'(RFC_CYC - 2); end
            S_RFC:  if (tmr == '0) state_d = S_IDLE;
            default: state_d = S_PWR;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_PWR;
            tmr       <= TW'(INIT_CYC - 1);
            ref_cnt   <= '0;
            cl3_q     <= 1'b0;
            init_done <= 1'b0;
            q_wr      <= 1'b0;
            q_bank    <= '0;
            q_row     <= '0;
            q_col     <= '0;
            q_data    <= '0;
        end else begin
            state <= state_d;
            tmr   <= tmr_d;
            if (state == S_PWR)  cl3_q   <= cfg_cas3;
            if (state == S_IREF) ref_cnt <= ref_cnt + 1'b1;
            if (state == S_IMRD && tmr == '0) init_done <= 1'b1;
            if (accept && !ref_pend) begin
                q_wr   <= req_write;
                q_bank <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
                q_row  <= req_addr[ROW_W+COL_W-1 -: ROW_W];
                q_col  <= req_addr[COL_W-1:0];
                q_data <= req_wdata;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        sd_dq_oe  = 1'b0;
        sd_dq_out = q_data;
        unique case (state)
            S_IPRE: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            S_IREF, S_REF: cmd = CMD_REF;
            S_IMRS: begin
                cmd = CMD_LMR;
                sd_addr[MR_CL_LSB +: 3] = cl3_q ? 3'd3 : 3'd2;
            end
            S_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = q_bank;
                sd_addr = q_row;
            end
            S_RW: begin
                cmd                  = q_wr ? CMD_WR : CMD_RD;
                sd_ba                = q_bank;
                sd_addr[COL_W-1:0]   = q_col;
                sd_dq_oe             = q_wr;
            end
            S_PRE: begin
                cmd   = CMD_PRE;
                sd_ba = q_bank;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    // ---------------- helpers ----------------
    sdram_row_timer #(
        .RAS_CYC(RAS_CYC),
        .RC_CYC (RC_CYC)
    ) u_row_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (cmd == CMD_ACT),
        .ras_ok(ras_ok),
        .rc_ok (rc_ok)
    );

    sdram_ref_timer #(
        .TRIG_CYC(REF_TRIG)
    ) u_ref_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (init_done),
        .ack  (state == S_REF),
        .pend (ref_pend)
    );

    sdram_rd_capture #(
        .DQ_W (DQ_W),
        .CL_LO(2),
        .CL_HI(3)
    ) u_rd_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (cmd == CMD_RD),
        .cl_hi_sel(cl3_q),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // ---------------- assertions ----------------
    p_act_rc_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> rc_ok);

    p_pre_after_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && init_done) |-> ras_ok);

    p_no_access_before_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !(cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR));

    p_ready_drops_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

endmodule

// File: tb/sdram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_US    = 2;
    localparam int INIT_CYC   = (INIT_US * 1000 + 5) / 6;
    localparam int RAS_MIN    = 7;
    localparam int RC_MIN     = 10;
    localparam int RCD_MIN    = 3;
    localparam int RP_MIN     = 3;
    localparam int RFC_MIN    = 10;
    localparam int REF_MAX    = 64000000 / 4096 / 6;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cas3 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ready, rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hBAD0;

    sdram_seq_ctrl #(.INIT_US(INIT_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          cyc = 0, since = 0, stage = 0, init_refs = 0, cl = 2;
    int          last_act, last_pre, last_ref;
    bit          open_row = 0, late_seen = 0, prev_accept = 0;
    int          open_ba = 0, open_rw = 0;
    bit          pend_wr = 0;
    int          pend_addr = 0;
    logic [15:0] pend_data = '0;
    logic [15:0] sdmem  [int];
    logic [15:0] shadow [int];
    int          dq_due[$];
    logic [15:0] dq_val[$];
    int          rdv_due[$];
    logic [15:0] exp_q[$];

    function automatic logic [15:0] blank(input int key);
        return key[15:0] ^ 16'h5A5A;
    endfunction

    always @(negedge clk) begin
        logic [3:0] cmd;
        int key;
        cyc++;
        cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst_n) begin
            stage = 0; since = 0; init_refs = 0; open_row = 0; late_seen = 0;
            prev_accept = 0;
            last_act = -100000; last_pre = -100000; last_ref = -100000;
            cl = cfg_cas3 ? 3 : 2;
            dq_due.delete(); dq_val.delete(); rdv_due.delete(); exp_q.delete();
            sd_dq_in = 16'hBAD0;
            chk(ready == 1'b0, "R12", "ready in reset", ready, 0);
            chk(cmd == 4'b0111, "R1", "NOP in reset", cmd, 4'b0111);
        end else begin
            since++;
            chk(cmd inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111},
                "R1", "command code", cmd, 4'b0111);
            case (cmd)
                4'b0010: begin
                    if (stage == 0) begin
                        chk(since > INIT_CYC, "R2", "NOP cycles before PRE", since - 1, INIT_CYC);
                        chk(sd_addr[10] == 1'b1, "R2", "init PRE all-banks bit", sd_addr[10], 1);
                        stage = 1;
                    end else begin
                        chk(open_row, "R8", "PRE closes open row", open_row, 1);
                        chk(sd_addr[10] == 1'b0, "R8", "single-bank PRE", sd_addr[10], 0);
                        chk(sd_ba == open_ba, "R8", "PRE bank", sd_ba, open_ba);
                        chk(cyc - last_act >= RAS_MIN, "R6", "ACT->PRE", cyc - last_act, RAS_MIN);
                        open_row = 0;
                    end
                    last_pre = cyc;
                end
                4'b0001: begin
                    chk(!open_row, "R8", "REF with row open", open_row, 0);
                    chk(cyc - last_pre >= RP_MIN, "R7", "PRE->REF", cyc - last_pre, RP_MIN);
                    chk(cyc - last_ref >= RFC_MIN, "R7", "REF->REF", cyc - last_ref, RFC_MIN);
                    if (stage == 1) begin
                        init_refs++;
                        if (init_refs == 2) stage = 2;
                    end else begin
                        chk(stage == 3, "R2", "extra REF before mode load", stage, 3);
                        chk(cyc - last_ref <= REF_MAX, "R9", "REF spacing", cyc - last_ref, REF_MAX);
                    end
                    last_ref = cyc;
                end
                4'b0000: begin
                    chk(stage == 2, "R2", "mode load order", stage, 2);
                    chk(sd_addr == 12'(cl << 4), "R3", "mode word", sd_addr, cl << 4);
                    chk(cyc - last_ref >= RFC_MIN, "R7", "REF->LMR", cyc - last_ref, RFC_MIN);
                    stage = 3;
                end
                4'b0011: begin
                    chk(stage == 3, "R2", "ACT before init done", stage, 3);
                    chk(!open_row, "R8", "second open row", open_row, 0);
                    chk(cyc - last_act >= RC_MIN, "R6", "ACT->ACT", cyc - last_act, RC_MIN);
                    chk(cyc - last_pre >= RP_MIN, "R7", "PRE->ACT", cyc - last_pre, RP_MIN);
                    chk(cyc - last_ref >= RFC_MIN, "R7", "REF->ACT", cyc - last_ref, RFC_MIN);
                    chk(sd_ba == pend_addr[21:20], "R4", "ACT bank", sd_ba, pend_addr[21:20]);
                    chk(sd_addr == pend_addr[19:8], "R4", "ACT row", sd_addr, pend_addr[19:8]);
                    open_row = 1; open_ba = sd_ba; open_rw = sd_addr; last_act = cyc;
                end
                4'b0100, 4'b0101: begin
                    chk(open_row && sd_ba == open_ba, "R8", "column cmd on open bank", sd_ba, open_ba);
                    chk(cyc - last_act >= RCD_MIN, "R5", "ACT->RW", cyc - last_act, RCD_MIN);
                    chk(sd_addr == {4'b0, pend_addr[7:0]}, "R4", "column address",
                        sd_addr, pend_addr[7:0]);
                    chk((cmd == 4'b0100) == pend_wr, "R4", "direction", cmd, pend_wr ? 4 : 5);
                    key = {open_ba[1:0], open_rw[11:0], sd_addr[7:0]};
                    if (cmd == 4'b0100) begin
                        chk(sd_dq_out == pend_data, "R10", "write data", sd_dq_out, pend_data);
                        sdmem[key] = sd_dq_out;
                    end else begin
                        dq_due.push_back(cyc + cl);
                        dq_val.push_back(sdmem.exists(key) ? sdmem[key] : blank(key));
                        rdv_due.push_back(cyc + cl + 1);
                    end
                end
                default: ;
            endcase
            chk(sd_dq_oe == (cmd == 4'b0100), "R10", "drive enable", sd_dq_oe, cmd == 4'b0100);
            if (prev_accept) chk(!ready, "R12", "ready after accept", ready, 0);
            if (ready) chk(stage == 3 && !open_row, "R12", "ready while busy", stage, 3);
            prev_accept = ready && req_valid;
            if (prev_accept) begin
                pend_wr = req_write; pend_addr = req_addr; pend_data = req_wdata;
                if (req_write) shadow[req_addr] = req_wdata;
                else exp_q.push_back(shadow.exists(req_addr) ? shadow[req_addr] : blank(req_addr));
            end
            if (stage == 3 && !late_seen && cyc - last_ref > REF_MAX) begin
                late_seen = 1;
                chk(0, "R9", "refresh overdue", cyc - last_ref, REF_MAX);
            end
            if (rd_valid) begin
                if (rdv_due.size() == 0 || exp_q.size() == 0) begin
                    chk(0, "R11", "unexpected rd_valid", cyc, 0);
                end else begin
                    chk(rdv_due[0] == cyc, "R11", "read strobe cycle", cyc, rdv_due[0]);
                    chk(rd_data == exp_q[0], "R11", "read data", rd_data, exp_q[0]);
                    void'(rdv_due.pop_front());
                    void'(exp_q.pop_front());
                end
            end else if (rdv_due.size() != 0 && rdv_due[0] <= cyc) begin
                chk(0, "R11", "missing rd_valid", cyc, rdv_due[0]);
                void'(rdv_due.pop_front());
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            if (dq_due.size() != 0 && dq_due[0] == cyc) begin
                sd_dq_in = dq_val[0];
                void'(dq_due.pop_front());
                void'(dq_val.pop_front());
            end else begin
                sd_dq_in = 16'hBAD0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input bit cas3);
        @(posedge clk); #1;
        rst_n = 1'b0; cfg_cas3 = cas3; req_valid = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic do_req(input bit wr, input logic [21:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!ready);
    endtask

    task automatic go_idle(input int n);
        @(posedge clk); #1 req_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        chk(0, "R12", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);                       // R3: latency two
        wait_ready();
        do_req(1, 22'h000010, 16'h1111);      // R4: bank 0
        do_req(1, 22'h1ABC05, 16'h2222);      // bank 1
        do_req(1, 22'h2FFFFF, 16'h3333);      // bank 2, top row/column
        do_req(1, 22'h300000, 16'h4444);      // bank 3
        do_req(0, 22'h000010, 16'h0);
        do_req(0, 22'h1ABC05, 16'h0);
        do_req(0, 22'h2FFFFF, 16'h0);
        do_req(0, 22'h300000, 16'h0);
        do_req(0, 22'h123456, 16'h0);         // never written
        go_idle(20);
        cfg_cas3 = 1'b1;                      // R3: no effect until next reset
        do_req(0, 22'h1ABC05, 16'h0);
        for (int i = 0; i < 300; i++) begin   // R9: requests on every cycle
            do_req((i % 3) == 0, 22'((i * 22'h01357) & 22'h3FF0FF), 16'(i * 16'h0101 + 7));
        end
        go_idle(6000);                        // R9: idle refresh spacing
        do_reset(1'b1);                       // R3/R11: latency three
        wait_ready();
        do_req(1, 22'h0A0B0C, 16'hBEEF);
        do_req(0, 22'h0A0B0C, 16'h0);
        do_req(0, 22'h3C0D01, 16'h0);
        do_req(1, 22'h3C0D01, 16'hCAFE);
        do_req(0, 22'h3C0D01, 16'h0);
        go_idle(100);
        chk(exp_q.size() == 0, "R11", "reads outstanding at end", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule